// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside the fetch and execute stages of a small 8-bit processor core. It watches a set of level-sensitive interrupt request lines and the global interrupt enable flag. At each instruction boundary it decides whether to take an interrupt. A core that is asleep can also be woken directly by an enabled, pending request, with no boundary. Once a request is accepted, the sequencer stalls the core and clears the global enable. It pushes the two-byte return address onto a stack that grows downward, then tells the fetch stage to restart at the vector of the winning request.

A return-from-interrupt instruction that completes hands control back to the sequencer. The sequencer pops the return address, moves the stack pointer back up by two, restores the global enable and reloads the program counter. The block owns the stack pointer, which software can load while the core is not stalled. Stack bytes travel over a simple byte-wide memory port. Read data from that port arrives one cycle after the read strobe.

Top module: `irq_seq`

## Requirements
- R1: After reset, gie_o is 0, busy_o is 0, pc_ld_o, mem_we_o and mem_re_o are 0, irq_ack_o is all zero, and sp_o equals the parameter SP_RST (default 16'h00FF).
- R2: At the boundary where sei_i is high, gie_o becomes 1 but no interrupt is accepted, even when a request is pending. The next boundary accepts a pending request.
- R3: Outside sleep, a request is accepted only in a cycle with insn_done_i high. Cycles of a multi-cycle instruction, in which insn_done_i stays low, never start entry.
- R4: Entry takes four cycles. If acceptance happens in cycle t, busy_o is high in cycles t+1 to t+4, and pc_ld_o pulses in cycle t+4 with pc_ld_val_o = VEC_BASE + 2*index (default VEC_BASE = 16'h0002).
- R5: When several requests are pending, the lowest index wins. In cycle t+1, irq_ack_o is the one-hot bit of that index.
- R6: Entry writes pc_i[7:0] to address sp in cycle t+1 and pc_i[15:8] to address sp-1 in cycle t+2, where pc_i is sampled in cycle t. It leaves sp_o two lower than before.
- R7: gie_o reads 0 from cycle t+1 on, and stays 0 until software sets it or a return completes.
- R8: With sleep_i high, gie_o set and any request pending, a request is accepted with no boundary. pc_ld_o then pulses startup_cyc_i + 8 cycles after acceptance.
- R9: A boundary with reti_i high in cycle t starts a return. The high byte is read from sp+1 in cycle t+1 and the low byte from sp+2 in cycle t+2. pc_ld_o pulses in cycle t+4 with the popped address. After that, sp_o is two higher, gie_o is 1, and the first boundary after the return accepts no interrupt.
- R10: A boundary with cli_i high clears gie_o and accepts no interrupt.
- R11: A cycle with sp_ld_i high and busy_o low sets sp_o to sp_ld_val_i in the next cycle.
- R12: While gie_o is 0, no request is accepted, neither at a boundary nor from sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | NUM_IRQ | Level request lines, bit i selects vector i |
| insn_done_i | input | 1 | Instruction boundary strobe |
| sei_i | input | 1 | Completing instruction sets the global enable |
| cli_i | input | 1 | Completing instruction clears the global enable |
| reti_i | input | 1 | Completing instruction is a return from interrupt |
| sleep_i | input | 1 | Core is asleep |
| startup_cyc_i | input | SU_W | Oscillator start-up cycles added on wake |
| pc_i | input | 16 | Return address offered by the core |
| sp_ld_i | input | 1 | Load the stack pointer |
| sp_ld_val_i | input | SP_W | Value for a stack pointer load |
| mem_rdata_i | input | 8 | Stack read data, valid the cycle after mem_re_o |
| gie_o | output | 1 | Global interrupt enable |
| busy_o | output | 1 | Sequence running, core stalled |
| irq_ack_o | output | NUM_IRQ | One-hot acknowledge of the accepted request |
| pc_ld_o | output | 1 | Fetch restarts at pc_ld_val_o |
| pc_ld_val_o | output | 16 | Vector or popped return address |
| sp_o | output | SP_W | Stack pointer |
| mem_we_o | output | 1 | Stack write strobe |
| mem_re_o | output | 1 | Stack read strobe |
| mem_addr_o | output | SP_W | Stack address |
| mem_wdata_o | output | 8 | Stack write data |

## Verification
The bench first checks that the enable shadow blocks a pending request both after sei and after a return. A design that leaked an interrupt there would raise busy_o one boundary early. It also checks that cli and a cleared enable suppress acceptance, including a wake from sleep while interrupts are off. It counts the cycles from acceptance to pc_ld_o for normal entry, for sleep entry with several start-up values and for the return. An off-by-one in the penalty or start-up arithmetic shows up there as a wrong count. Random request masks, PCs and stack pointers are then used to compare the bytes in the bench's stack memory, the acknowledged index and the restored PC and stack pointer. A swapped push order or a wrong priority direction would corrupt the round trip.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int unsigned PC_W      = 16;
  localparam int unsigned PHASE_CYC = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAKE,
    ST_ENT,
    ST_RET
  } seq_st_e;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N     = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     onehot_o
);
  // scan downward so the lowest set bit is the last written
  always_comb begin
    idx_o    = '0;
    onehot_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o    = IDX_W'(i);
        onehot_o = '0;
        onehot_o[i] = 1'b1;
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int unsigned SU_W      = 8,
  parameter int unsigned SLEEP_PEN = 4,
  localparam int unsigned CNT_W    = SU_W + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            insn_done_i,
  input  logic            sei_i,
  input  logic            cli_i,
  input  logic            reti_i,
  input  logic            sleep_i,
  input  logic [SU_W-1:0] startup_i,
  input  logic            any_i,
  output logic            gie_o,
  output logic            busy_o,
  output logic            take_o,
  output logic            push_lo_o,
  output logic            push_hi_o,
  output logic            pop_hi_o,
  output logic            pop_lo_o,
  output logic            cap_hi_o,
  output logic            cap_lo_o,
  output logic            ld_vec_o,
  output logic            ld_ret_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_CYC - 1);

  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             gie_q;
  logic             shadow_q;
  logic             take_norm, take_sleep, start_ret;

  always_comb begin
    take_norm  = (st_q == ST_IDLE) && insn_done_i && gie_q && any_i &&
                 !sei_i && !cli_i && !reti_i && !shadow_q;
    take_sleep = (st_q == ST_IDLE) && !insn_done_i && sleep_i && gie_q && any_i;
    start_ret  = (st_q == ST_IDLE) && insn_done_i && reti_i;
  end

  assign take_o = take_norm | take_sleep;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      gie_q    <= 1'b0;
      shadow_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (take_o) begin
            gie_q <= 1'b0;
            if (take_sleep) begin
              st_q  <= ST_WAKE;
              cnt_q <= CNT_W'(startup_i) + CNT_W'(SLEEP_PEN - 1);
            end else begin
              st_q  <= ST_ENT;
              cnt_q <= '0;
            end
          end else if (start_ret) begin
            st_q     <= ST_RET;
            cnt_q    <= '0;
            shadow_q <= 1'b0;
          end else if (insn_done_i) begin
            shadow_q <= 1'b0;
            if (sei_i)      gie_q <= 1'b1;
            else if (cli_i) gie_q <= 1'b0;
          end
        end
        ST_WAKE: begin
          if (cnt_q == '0) st_q <= ST_ENT;
          else             cnt_q <= cnt_q - 1'b1;
        end
        ST_ENT: begin
          if (cnt_q == LAST) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RET: begin
          if (cnt_q == LAST) begin
            st_q     <= ST_IDLE;
            cnt_q    <= '0;
            gie_q    <= 1'b1;
            shadow_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    push_lo_o = (st_q == ST_ENT) && (cnt_q == CNT_W'(0));
    push_hi_o = (st_q == ST_ENT) && (cnt_q == CNT_W'(1));
    ld_vec_o  = (st_q == ST_ENT) && (cnt_q == LAST);
    pop_hi_o  = (st_q == ST_RET) && (cnt_q == CNT_W'(0));
    pop_lo_o  = (st_q == ST_RET) && (cnt_q == CNT_W'(1));
    cap_hi_o  = pop_lo_o;
    cap_lo_o  = (st_q == ST_RET) && (cnt_q == CNT_W'(2));
    ld_ret_o  = (st_q == ST_RET) && (cnt_q == LAST);
  end

  assign gie_o  = gie_q;
  assign busy_o = (st_q != ST_IDLE);

  p_boundary_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) && !$past(sleep_i) |-> $past(insn_done_i));

  p_gie_low_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ENT || st_q == ST_WAKE) |-> !gie_q);

  p_ret_sets_gie_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ret_o |=> gie_q && !busy_o);

  p_no_take_off_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !gie_q) |=> !(st_q == ST_ENT || st_q == ST_WAKE));
endmodule

// File: rtl/irq_stack_port.sv
module irq_stack_port
  import irq_seq_pkg::*;
#(
  parameter int unsigned SP_W   = 16,
  parameter logic [SP_W-1:0] SP_RST = SP_W'(16'h00FF)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            idle_i,
  input  logic            sp_ld_i,
  input  logic [SP_W-1:0] sp_ld_val_i,
  input  logic            take_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            push_lo_i,
  input  logic            push_hi_i,
  input  logic            pop_hi_i,
  input  logic            pop_lo_i,
  input  logic            cap_hi_i,
  input  logic            cap_lo_i,
  input  logic [7:0]      mem_rdata_i,
  output logic            mem_we_o,
  output logic            mem_re_o,
  output logic [SP_W-1:0] mem_addr_o,
  output logic [7:0]      mem_wdata_o,
  output logic [SP_W-1:0] sp_o,
  output logic [PC_W-1:0] ret_pc_o
);
  logic [SP_W-1:0] sp_q;
  logic [PC_W-1:0] pc_q;
  logic [7:0]      hi_q, lo_q;
  logic            pop;

  assign pop = pop_hi_i | pop_lo_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= SP_RST;
      pc_q <= '0;
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (take_i) pc_q <= pc_i;
      if (push_lo_i || push_hi_i)  sp_q <= sp_q - SP_W'(1);
      else if (pop)                sp_q <= sp_q + SP_W'(1);
      else if (idle_i && sp_ld_i)  sp_q <= sp_ld_val_i;
      if (cap_hi_i) hi_q <= mem_rdata_i;
      if (cap_lo_i) lo_q <= mem_rdata_i;
    end
  end

  // low byte goes in first, so it sits at the higher address
  always_comb begin
    mem_we_o    = push_lo_i | push_hi_i;
    mem_re_o    = pop;
    mem_addr_o  = pop ? sp_q + SP_W'(1) : sp_q;
    mem_wdata_o = push_hi_i ? pc_q[15:8] : (push_lo_i ? pc_q[7:0] : 8'h00);
  end

  assign sp_o     = sp_q;
  assign ret_pc_o = {hi_q, lo_q};

  p_push_dec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_lo_i |=> push_hi_i && (sp_q == $past(sp_q) - SP_W'(1)));

  p_pop_inc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_hi_i |=> pop_lo_i && (sp_q == $past(sp_q) + SP_W'(1)));
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned NUM_IRQ   = 8,
  parameter int unsigned SP_W      = 16,
  parameter int unsigned SU_W      = 8,
  parameter int unsigned SLEEP_PEN = 4,
  parameter logic [SP_W-1:0] SP_RST   = SP_W'(16'h00FF),
  parameter logic [15:0]     VEC_BASE = 16'h0002,
  localparam int unsigned IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_req_i,
  input  logic               insn_done_i,
  input  logic               sei_i,
  input  logic               cli_i,
  input  logic               reti_i,
  input  logic               sleep_i,
  input  logic [SU_W-1:0]    startup_cyc_i,
  input  logic [15:0]        pc_i,
  input  logic               sp_ld_i,
  input  logic [SP_W-1:0]    sp_ld_val_i,
  input  logic [7:0]         mem_rdata_i,
  output logic               gie_o,
  output logic               busy_o,
  output logic [NUM_IRQ-1:0] irq_ack_o,
  output logic               pc_ld_o,
  output logic [15:0]        pc_ld_val_o,
  output logic [SP_W-1:0]    sp_o,
  output logic               mem_we_o,
  output logic               mem_re_o,
  output logic [SP_W-1:0]    mem_addr_o,
  output logic [7:0]         mem_wdata_o
);
  logic               any, take;
  logic [IDX_W-1:0]   idx;
  logic [NUM_IRQ-1:0] win;
  logic               push_lo, push_hi, pop_hi, pop_lo, cap_hi, cap_lo;
  logic               ld_vec, ld_ret;
  logic [PC_W-1:0]    vec_q, ret_pc;
  logic [NUM_IRQ-1:0] ack_q;

  irq_prio_enc #(.N(NUM_IRQ)) u_prio (
    .req_i    (irq_req_i),
    .any_o    (any),
    .idx_o    (idx),
    .onehot_o (win)
  );

  irq_seq_ctrl #(.SU_W(SU_W), .SLEEP_PEN(SLEEP_PEN)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .insn_done_i (insn_done_i),
    .sei_i       (sei_i),
    .cli_i       (cli_i),
    .reti_i      (reti_i),
    .sleep_i     (sleep_i),
    .startup_i   (startup_cyc_i),
    .any_i       (any),
    .gie_o       (gie_o),
    .busy_o      (busy_o),
    .take_o      (take),
    .push_lo_o   (push_lo),
    .push_hi_o   (push_hi),
    .pop_hi_o    (pop_hi),
    .pop_lo_o    (pop_lo),
    .cap_hi_o    (cap_hi),
    .cap_lo_o    (cap_lo),
    .ld_vec_o    (ld_vec),
    .ld_ret_o    (ld_ret)
  );

  irq_stack_port #(.SP_W(SP_W), .SP_RST(SP_RST)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idle_i      (!busy_o),
    .sp_ld_i     (sp_ld_i),
    .sp_ld_val_i (sp_ld_val_i),
    .take_i      (take),
    .pc_i        (pc_i),
    .push_lo_i   (push_lo),
    .push_hi_i   (push_hi),
    .pop_hi_i    (pop_hi),
    .pop_lo_i    (pop_lo),
    .cap_hi_i    (cap_hi),
    .cap_lo_i    (cap_lo),
    .mem_rdata_i (mem_rdata_i),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .sp_o        (sp_o),
    .ret_pc_o    (ret_pc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q <= '0;
      ack_q <= '0;
    end else begin
      ack_q <= take ? win : '0;
      if (take) vec_q <= VEC_BASE + (PC_W'(idx) << 1);
    end
  end

  assign irq_ack_o   = ack_q;
  assign pc_ld_o     = ld_vec | ld_ret;
  assign pc_ld_val_o = ld_vec ? vec_q : ret_pc;

  p_ack_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_q != '0) |-> $onehot(ack_q) && busy_o);

  p_pc_ld_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_ld_o |=> !pc_ld_o && !busy_o);

  p_we_in_seq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o) |-> busy_o);
endmodule

// File: tb/irq_seq_test.sv
module irq_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 8;
  localparam logic [15:0] VBASE = 16'h0002;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] req = '0;
  logic          done = 0, sei = 0, cli = 0, reti = 0, slp = 0;
  logic [7:0]    su = '0;
  logic [15:0]   pc = '0;
  logic          spld = 0;
  logic [15:0]   spval = '0;
  logic [7:0]    rdata;
  logic          gie, busy, pcld, we, re;
  logic [NI-1:0] ack;
  logic [15:0]   pcv, sp, addr;
  logic [7:0]    wdata;
  logic [7:0]    mem [256];

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .insn_done_i(done),
    .sei_i(sei), .cli_i(cli), .reti_i(reti), .sleep_i(slp),
    .startup_cyc_i(su), .pc_i(pc), .sp_ld_i(spld), .sp_ld_val_i(spval),
    .mem_rdata_i(rdata), .gie_o(gie), .busy_o(busy), .irq_ack_o(ack),
    .pc_ld_o(pcld), .pc_ld_val_o(pcv), .sp_o(sp), .mem_we_o(we),
    .mem_re_o(re), .mem_addr_o(addr), .mem_wdata_o(wdata)
  );

  always_ff @(posedge clk) begin
    if (we) mem[addr[7:0]] <= wdata;
    if (re) rdata <= mem[addr[7:0]];
  end

  function automatic int low_idx(logic [NI-1:0] m);
    for (int i = NI - 1; i >= 0; i--) if (m[i]) low_idx = i;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic boundary(bit s, bit c);
    done = 1; sei = s; cli = c;
    @(negedge clk);
    done = 0; sei = 0; cli = 0;
  endtask

  task automatic load_sp(logic [15:0] v);
    spld = 1; spval = v;
    @(negedge clk);
    spld = 0;
    chk(sp == v, "R11 sp load", sp, v);
  endtask

  // accept by boundary (sleep_mode=0) or from sleep; checks R4 R5 R6 R7 R8
  task automatic entry(logic [NI-1:0] m, logic [15:0] p, bit sleep_mode, logic [7:0] s);
    int n = 0;
    int idx = low_idx(m);
    logic [15:0] sp0 = sp;
    int exp_n = sleep_mode ? int'(s) + 8 : 4;
    int we_seen = 0;
    pc = p; su = s;
    if (sleep_mode) begin slp = 1; req = m; end
    else begin req = m; done = 1; end
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        done = 0; slp = 0;
        chk(ack == (NI'(1) << idx), "R5 ack onehot", ack, NI'(1) << idx);
        chk(!gie && busy, "R7 gie cleared busy set", {gie, busy}, 2'b01);
      end
      if (we) begin
        we_seen++;
        if (we_seen == 1) chk(addr == sp0 && wdata == p[7:0], "R6 low push", {addr, wdata}, {sp0, p[7:0]});
        else chk(addr == sp0 - 16'd1 && wdata == p[15:8], "R6 high push", {addr, wdata}, {sp0 - 16'd1, p[15:8]});
      end
    end while (!pcld && n < 400);
    chk(n == exp_n, sleep_mode ? "R8 sleep entry cycles" : "R4 entry cycles", n, exp_n);
    chk(pcv == VBASE + 16'(2 * idx), "R4 vector", pcv, VBASE + 16'(2 * idx));
    req = '0;
    @(negedge clk);
    chk(sp == sp0 - 16'd2 && we_seen == 2, "R6 sp after push", sp, sp0 - 16'd2);
    chk(!busy && !gie, "R7 idle gie low", {busy, gie}, 2'b00);
  endtask

  task automatic ret(logic [15:0] p);
    int n = 0;
    logic [15:0] sp0 = sp;
    done = 1; reti = 1;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin done = 0; reti = 0; end
      if (n == 1) chk(re && addr == sp0 + 16'd1, "R9 high pop addr", addr, sp0 + 16'd1);
      if (n == 2) chk(re && addr == sp0 + 16'd2, "R9 low pop addr", addr, sp0 + 16'd2);
    end while (!pcld && n < 400);
    chk(n == 4, "R9 return cycles", n, 4);
    chk(pcv == p, "R9 popped pc", pcv, p);
    @(negedge clk);
    chk(gie && sp == sp0 + 16'd2, "R9 gie and sp", {gie, sp}, {1'b1, sp0 + 16'd2});
    // shadow: first boundary after return takes nothing
    req = 8'h10;
    boundary(0, 0);
    chk(!busy, "R9 shadow after return", busy, 0);
    req = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!gie && !busy && !pcld && !we && !re && ack == '0 && sp == 16'h00FF,
        "R1 reset state", {gie, busy, sp}, {2'b00, 16'h00FF});
    rst_n = 1;
    @(negedge clk);
    chk(!gie && !busy && sp == 16'h00FF, "R1 after release", {gie, busy, sp}, {2'b00, 16'h00FF});

    load_sp(16'h00C0);

    // R12: disabled, pending request at boundary and from sleep
    req = 8'h04;
    boundary(0, 0);
    chk(!busy, "R12 boundary while disabled", busy, 0);
    slp = 1;
    repeat (3) @(negedge clk);
    chk(!busy, "R12 sleep while disabled", busy, 0);
    slp = 0;

    // R2: sei boundary with request pending
    boundary(1, 0);
    chk(gie && !busy, "R2 sei shadow", {gie, busy}, 2'b10);
    req = '0;
    // R10: cli boundary with request pending
    req = 8'h02;
    boundary(0, 1);
    chk(!gie && !busy, "R10 cli blocks", {gie, busy}, 2'b00);
    req = '0;
    boundary(1, 0);
    boundary(0, 0);

    // R3: long instruction, no boundary
    req = 8'h80;
    repeat (5) @(negedge clk);
    chk(!busy, "R3 no entry mid instruction", busy, 0);
    entry(8'h80, 16'h1234, 0, 8'd0);
    ret(16'h1234);

    // R2: second boundary after sei accepts; set shadow case with gie already 1
    req = 8'h06;
    boundary(1, 0);
    chk(!busy, "R2 sei shadow with gie set", busy, 0);
    entry(8'h06, 16'hBEEF, 0, 8'd0);
    ret(16'hBEEF);

    // R8 directed start-up values
    entry(8'h01, 16'h0F0E, 1, 8'd0);
    ret(16'h0F0E);
    entry(8'h30, 16'hA55A, 1, 8'd5);
    ret(16'hA55A);

    // random mix
    for (int it = 0; it < 30; it++) begin
      logic [NI-1:0] m = NI'($urandom_range(1, (1 << NI) - 1));
      logic [15:0] p = 16'($urandom);
      bit sm = ($urandom_range(0, 2) == 0);
      logic [7:0] s = 8'($urandom_range(0, 12));
      load_sp(16'h0020 + 16'($urandom_range(0, 16'hC0)));
      if (!gie) boundary(1, 0);
      boundary(0, 0);
      entry(m, p, sm, s);
      repeat ($urandom_range(0, 3)) boundary(0, 0);
      ret(p);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule